// File: doc/BRIEF.md
# Channel Status Capture Buffer

This block gathers the 192-bit channel-status block that a biphase audio stream spreads across 192 consecutive frames, one bit per subframe. An upstream decoder delivers subframes that are already decoded. Each subframe comes with a valid strobe, a channel flag (A or B), the status bit and a flag that marks the first frame of a block. A source-select input chooses which channel's bits are collected. The stream may carry one channel or two, and with two the A and B subframes alternate.

Bits are assembled in a working register. The completed block is copied into a read-side buffer in a single clock edge, only when the 192nd bit of the block arrives. A processor therefore always reads one whole block and never a mix of two. Reads go through a 3-bit word select that places one 32-bit slice of the block on a combinational read port. A block-valid flag reports that at least one complete block has been captured since reset or since the block was last enabled.

Top module: `cs_capture_top`

## Requirements
- R1: After reset, `blk_valid` is 0 and every read word is 0.
- R2: Status bit k of a block (k = 0 is the bit carried by the block-start subframe) appears at bit k mod 32 of word k / 32. Equivalently, status byte 4*sel+j sits at bits 8j+7..8j of word sel, and the earliest received bit of each byte is its bit 0.
- R3: Only subframes whose channel flag equals `src_sel` are captured, with 0 meaning channel A and 1 meaning channel B. Subframes of the other channel have no effect on the read data.
- R4: A subframe with the block-start flag set restarts collection at bit 0 and stores its own bit there. A partial block that was in progress is dropped.
- R5: Bits that arrive before the first block start, or after the 192nd bit and before the next block start, are ignored.
- R6: The read buffer changes only on the clock edge that captures the 192nd bit of a block. Until then it holds the previous complete block.
- R7: Word-select values 6 and 7 read as zero.
- R8: `blk_valid` rises on the first completed block and stays high. Reset or `enable` low clears it, and `enable` low also drops any partial block.
- R9: Cycles with `sf_valid` low have no effect, whatever the other subframe inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture enable; low clears the flag and drops a partial block |
| src_sel | input | 1 | Source channel: 0 = A, 1 = B |
| sf_valid | input | 1 | A decoded subframe is present this cycle |
| sf_chan | input | 1 | Channel of the subframe: 0 = A, 1 = B |
| sf_cs_bit | input | 1 | Channel-status bit carried by the subframe |
| sf_blk_start | input | 1 | Subframe belongs to the first frame of a block |
| word_sel | input | 3 | Selects the 32-bit word on `rd_data` (0 to 5) |
| rd_data | output | 32 | Selected word of the last complete block |
| blk_valid | output | 1 | At least one complete block has been captured |

## Verification
A bit counter that drifts by even one position shows up as the whole read block shifted by one bit. This appears in the first completed block after the fault, because every word differs from the expected pattern. A commit that fires early, or a channel qualifier that is wrong, changes `rd_data` at a point where the previous block should still be visible. Partial blocks, trailing bits and disable mid-block are therefore each followed by a full read-back. A flag that is not cleared shows at once on `blk_valid` after a disable, before any new block has arrived.

// File: rtl/cs_capture_pkg.sv
package cs_capture_pkg;
  localparam int unsigned CS_BLOCK_BITS = 192;
  localparam int unsigned CS_WORD_BITS  = 32;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } cs_chan_e;
endpackage

// File: rtl/cs_bit_seq.sv
module cs_bit_seq #(
  parameter int BLK_BITS = 192,
  localparam int CNT_W = $clog2(BLK_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             take,
  input  logic             blk_start,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic             commit
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_BITS - 1);

  logic             armed_q, armed_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    wr_en   = 1'b0;
    wr_idx  = cnt_q;
    commit  = 1'b0;
    if (!enable) begin
      armed_n = 1'b0;
      cnt_n   = '0;
    end else if (take) begin
      if (blk_start) begin
        wr_en   = 1'b1;
        wr_idx  = '0;
        cnt_n   = CNT_W'(1);
        armed_n = 1'b1;
      end else if (armed_q) begin
        wr_en = 1'b1;
        if (cnt_q == LAST_IDX) begin
          commit  = 1'b1;
          armed_n = 1'b0;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/cs_assembly.sv
module cs_assembly #(
  parameter int BLK_BITS = 192,
  localparam int CNT_W = $clog2(BLK_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CNT_W-1:0]    wr_idx,
  input  logic                wr_bit,
  output logic [BLK_BITS-1:0] asm_next
);
  logic [BLK_BITS-1:0] asm_q;

  for (genvar i = 0; i < BLK_BITS; i++) begin : g_bit
    always_comb begin
      asm_next[i] = asm_q[i];
      if (wr_en && (wr_idx == CNT_W'(i))) asm_next[i] = wr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
    end else if (wr_en) begin
      asm_q <= asm_next;
    end
  end
endmodule

// File: rtl/cs_commit_bank.sv
module cs_commit_bank #(
  parameter int BLK_BITS = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                commit,
  input  logic [BLK_BITS-1:0] blk_in,
  output logic [BLK_BITS-1:0] shadow,
  output logic                blk_valid
);
  logic valid_n;

  always_comb begin
    valid_n = blk_valid;
    if (!enable)     valid_n = 1'b0;
    else if (commit) valid_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (commit) begin
      shadow <= blk_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_valid <= 1'b0;
    else        blk_valid <= valid_n;
  end
endmodule

// File: rtl/cs_word_mux.sv
module cs_word_mux #(
  parameter int BLK_BITS = 192,
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = BLK_BITS / WORD_W,
  localparam int SEL_W = $clog2(NUM_WORDS)
) (
  input  logic [BLK_BITS-1:0] shadow,
  input  logic [SEL_W-1:0]    word_sel,
  output logic [WORD_W-1:0]   rd_data
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words[w] = shadow[w*WORD_W +: WORD_W];
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_sel == SEL_W'(w)) rd_data = words[w];
    end
  end
endmodule

// File: rtl/cs_capture_top.sv
module cs_capture_top
  import cs_capture_pkg::*;
#(
  parameter int BLK_BITS = CS_BLOCK_BITS,
  parameter int WORD_W = CS_WORD_BITS,
  localparam int NUM_WORDS = BLK_BITS / WORD_W,
  localparam int SEL_W = $clog2(NUM_WORDS),
  localparam int CNT_W = $clog2(BLK_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              src_sel,
  input  logic              sf_valid,
  input  logic              sf_chan,
  input  logic              sf_cs_bit,
  input  logic              sf_blk_start,
  input  logic [SEL_W-1:0]  word_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic              blk_valid
);
  cs_chan_e            src_chan, in_chan;
  logic                take;
  logic                wr_en;
  logic [CNT_W-1:0]    wr_idx;
  logic                commit;
  logic [BLK_BITS-1:0] asm_next;
  logic [BLK_BITS-1:0] shadow;

  assign src_chan = cs_chan_e'(src_sel);
  assign in_chan  = cs_chan_e'(sf_chan);
  assign take     = enable && sf_valid && (in_chan == src_chan);

  cs_bit_seq #(.BLK_BITS(BLK_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .take      (take),
    .blk_start (sf_blk_start),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .commit    (commit)
  );

  cs_assembly #(.BLK_BITS(BLK_BITS)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_bit   (sf_cs_bit),
    .asm_next (asm_next)
  );

  cs_commit_bank #(.BLK_BITS(BLK_BITS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .commit    (commit),
    .blk_in    (asm_next),
    .shadow    (shadow),
    .blk_valid (blk_valid)
  );

  cs_word_mux #(.BLK_BITS(BLK_BITS), .WORD_W(WORD_W)) u_mux (
    .shadow   (shadow),
    .word_sel (word_sel),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/cs_capture_chk.sv
module cs_capture_chk #(
  parameter int BLK_BITS = 192,
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = BLK_BITS / WORD_W,
  localparam int SEL_W = $clog2(NUM_WORDS),
  localparam int CNT_W = $clog2(BLK_BITS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic [SEL_W-1:0]    word_sel,
  input logic [WORD_W-1:0]   rd_data,
  input logic                blk_valid,
  input logic                commit,
  input logic                wr_en,
  input logic [CNT_W-1:0]    wr_idx,
  input logic [BLK_BITS-1:0] shadow
);
  // R7
  sel_oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(word_sel) >= NUM_WORDS) |-> (rd_data == '0));

  // R8
  disable_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !blk_valid);

  // R6
  buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(shadow));

  // R8
  valid_rise_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_valid) |-> $past(commit));

  // R6
  commit_at_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wr_en && (32'(wr_idx) == BLK_BITS - 1)));
endmodule

bind cs_capture_top cs_capture_chk #(.BLK_BITS(BLK_BITS), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .word_sel  (word_sel),
  .rd_data   (rd_data),
  .blk_valid (blk_valid),
  .commit    (commit),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .shadow    (shadow)
);

// File: tb/test_cs_capture_top.sv
`timescale 1ns/100ps
module test_cs_capture_top;
  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        src_sel;
  logic        sf_valid;
  logic        sf_chan;
  logic        sf_cs_bit;
  logic        sf_blk_start;
  logic [2:0]  word_sel;
  logic [31:0] rd_data;
  logic        blk_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_req = 0;

  typedef struct {
    logic [191:0] blk;
    logic         valid;
    string        tag;
  } exp_t;
  exp_t exp_q[$];

  cs_capture_top i_cs_capture_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .src_sel      (src_sel),
    .sf_valid     (sf_valid),
    .sf_chan      (sf_chan),
    .sf_cs_bit    (sf_cs_bit),
    .sf_blk_start (sf_blk_start),
    .word_sel     (word_sel),
    .rd_data      (rd_data),
    .blk_valid    (blk_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [191:0] make_pat(input int unsigned seed);
    logic [191:0] p;
    int unsigned x = seed;
    for (int k = 0; k < 192; k++) begin
      x = x * 32'd1103515245 + 32'd12345;
      p[k] = x[16];
    end
    return p;
  endfunction

  task automatic drive_sf(input logic ch, input logic b, input logic st);
    @(negedge clk);
    sf_valid = 1'b1; sf_chan = ch; sf_cs_bit = b; sf_blk_start = st;
  endtask

  task automatic go_idle();
    @(negedge clk);
    sf_valid = 1'b0; sf_chan = 1'b0; sf_cs_bit = 1'b0; sf_blk_start = 1'b0;
  endtask

  // Frames of A then B subframes; gap cycles carry junk with sf_valid low (R9)
  task automatic send_frames(input logic [191:0] pa, input logic [191:0] pb,
                             input int n, input bit with_start, input bit gaps);
    for (int k = 0; k < n; k++) begin
      logic st = with_start && (k == 0);
      drive_sf(1'b0, pa[k], st);
      drive_sf(1'b1, pb[k], st);
      if (gaps && (k % 17 == 5)) begin
        @(negedge clk);
        sf_valid = 1'b0; sf_chan = src_sel; sf_cs_bit = 1'b1; sf_blk_start = 1'b1;
      end
    end
    go_idle();
  endtask

  task automatic expect_state(input logic [191:0] blk, input logic v, input string tag);
    exp_t e;
    e.blk = blk; e.valid = v; e.tag = tag;
    exp_q.push_back(e);
    mon_req = 1'b1;
    wait (mon_req == 1'b0);
  endtask

  // Monitor: pops expected items and sweeps the read window
  initial begin
    forever begin
      exp_t e;
      wait (mon_req == 1'b1);
      e = exp_q.pop_front();
      checks++;
      if (blk_valid !== e.valid) begin
        errors++;
        $display("FAIL %s blk_valid actual %0b expected %0b", e.tag, blk_valid, e.valid);
      end
      for (int w = 0; w < 8; w++) begin
        logic [31:0] ew;
        word_sel = 3'(w);
        #0.2;
        ew = (w < 6) ? e.blk[32*w +: 32] : 32'h0;
        checks++;
        if (rd_data !== ew) begin
          errors++;
          $display("FAIL %s%s word %0d actual %08h expected %08h",
                   e.tag, (w >= 6) ? " R7" : " R2", w, rd_data, ew);
        end
      end
      word_sel = 3'd0;
      mon_req = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [191:0] pa [8];
    logic [191:0] pb [8];
    for (int i = 0; i < 8; i++) begin
      pa[i] = make_pat(32'(100 + i));
      pb[i] = make_pat(32'(900 + 7 * i));
    end
    rst_n = 1'b0; enable = 1'b0; src_sel = 1'b0; word_sel = 3'd0;
    sf_valid = 1'b0; sf_chan = 1'b0; sf_cs_bit = 1'b0; sf_blk_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state('0, 1'b0, "R1");

    enable = 1'b1;
    // R5: bits before the first block start are dropped
    send_frames(pa[0], pb[0], 10, 1'b0, 1'b0);
    expect_state('0, 1'b0, "R5");

    // R3 channel A, R9 gaps, R6 commit, R8 flag
    send_frames(pa[1], pb[1], 192, 1'b1, 1'b1);
    expect_state(pa[1], 1'b1, "R3/R6/R8/R9");

    // R3 channel B
    src_sel = 1'b1;
    send_frames(pa[2], pb[2], 192, 1'b1, 1'b0);
    expect_state(pb[2], 1'b1, "R3");

    // R6 partial block leaves old block visible
    send_frames(pa[3], pb[3], 100, 1'b1, 1'b0);
    expect_state(pb[2], 1'b1, "R6");

    // R4 restart drops partial block
    send_frames(pa[4], pb[4], 192, 1'b1, 1'b1);
    expect_state(pb[4], 1'b1, "R4");

    // R5 trailing bits without a new start
    send_frames(pa[5], pb[5], 30, 1'b0, 1'b0);
    expect_state(pb[4], 1'b1, "R5");

    // R8 disable mid-block clears flag and drops partial block
    send_frames(pa[6], pb[6], 100, 1'b1, 1'b0);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    send_frames(pa[6], pb[6], 92, 1'b0, 1'b0);
    expect_state(pb[4], 1'b0, "R8");

    // R2 fresh block after re-enable, channel A
    src_sel = 1'b0;
    send_frames(pa[7], pb[7], 192, 1'b1, 1'b0);
    expect_state(pa[7], 1'b1, "R2/R8");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule